// File: doc/BRIEF.md
# Two-Channel Eight-Bit PWM DAC with Alternate-Frame Blanking

Two pulse-width modulated outputs share one free-running frame counter of 255 clock steps. Each output is high for the first `value` steps of a frame, so an external RC low-pass filter produces an average of supply × value / 255. Duty values are loaded through a simple write port that selects a channel. A written value sits in a holding register and moves into the active comparator only at a frame boundary, so a frame never sees a mix of old and new duty.

Each channel has its own blanking enable. While it is set, the channel alternates between frames. In one frame it drives its normal PWM waveform. In the next frame it holds its output low for the whole frame. Channel 0 is meant for horizontal moire cancellation and channel 1 for vertical. The enables are sampled at frame boundaries only.

Top module: `pwm_moire_dac`

## Requirements
- R1: After reset both outputs are low, both duty values are 0, both channels are in the active (non-blanked) frame state, and the first frame after reset drives both outputs low.
- R2: A frame is exactly 255 clock cycles long. In a non-blanked frame with duty value v, the output is high for frame steps 0 to v-1 and low for the remaining steps.
- R3: In a non-blanked frame, a duty of 0 holds the output low for all 255 steps and a duty of 255 holds it high for all 255 steps.
- R4: A write with `wr_ch_i` = 0 updates only channel 0, and a write with `wr_ch_i` = 1 updates only channel 1.
- R5: A write made during a frame first takes effect in the following frame. If several writes reach the same channel within one frame, the last one is used.
- R6: When a channel's blanking enable is sampled high at two consecutive frame boundaries, the frame after the second boundary has the opposite state to the frame before it. The first frame after the enable is first sampled high is active. A blanked frame holds the output low for all 255 steps.
- R7: The blanking enable is sampled only at the frame boundary. A boundary at which it is sampled low starts an active frame, so PWM appears in every frame again from that boundary on.
- R8: The two channels' blanking states are independent, and a channel's state cannot change within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Duty write strobe, one value per high cycle |
| wr_ch_i | input | 1 | Channel selected by the write |
| wr_data_i | input | 8 | Duty value to write |
| moire_en_i | input | 2 | Per-channel alternate-frame blanking enable |
| pwm_o | output | 2 | PWM outputs, bit n for channel n |

## Verification
The bench runs 300 frames and compares every cycle of both outputs against an arithmetic model. Over that run every duty value from 0 to 255 reaches each channel, and the blanking enables switch on and off at varied points. Writes land in the middle of a frame, and a second write overrides the first. A design that loaded the duty straight away would produce a runt pulse and a wrong high count in that frame. A design that kept the first write, or that let a write reach the wrong channel, would show the wrong duty one frame later. An off-by-one comparator or frame length would fail at duty 0, 255, 1 or 254. Blanking that starts in the wrong phase, fails to release when the enable drops, or uses the enable in the middle of a frame would give whole frames of the wrong polarity.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  typedef enum logic {PH_ACTIVE = 1'b0, PH_BLANK = 1'b1} phase_e;
endpackage

// File: rtl/pmd_frame_timer.sv
module pmd_frame_timer #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [DW-1:0] LAST = DW'((1 << DW) - 2);

  logic [DW-1:0] cnt_q;

  assign wrap_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmd_channel.sv
module pmd_channel
  import pmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wrap_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          moire_en_i,
  output logic          pwm_o,
  output logic [DW-1:0] duty_o,
  output logic          blank_o
);
  logic [DW-1:0] shadow_q, shadow_d, active_q;
  logic          men_q;
  phase_e        phase_q;

  assign shadow_d = wr_i ? wr_data_i : shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
      men_q    <= 1'b0;
      phase_q  <= PH_ACTIVE;
    end else begin
      shadow_q <= shadow_d;
      if (wrap_i) begin
        active_q <= shadow_d;
        men_q    <= moire_en_i;
        // first enabled frame is active; alternate only while enable persists
        if (men_q && moire_en_i)
          phase_q <= (phase_q == PH_ACTIVE) ? PH_BLANK : PH_ACTIVE;
        else
          phase_q <= PH_ACTIVE;
      end
    end
  end

  assign pwm_o   = (phase_q == PH_ACTIVE) && (cnt_i < active_q);
  assign duty_o  = active_q;
  assign blank_o = (phase_q == PH_BLANK);
endmodule

// File: rtl/pwm_moire_dac.sv
module pwm_moire_dac #(
  parameter int NUM_CH = 2,
  parameter int DW     = 8,
  localparam int CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CW-1:0]     wr_ch_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [NUM_CH-1:0] moire_en_i,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [DW-1:0]             cnt_w;
  logic                      wrap_w;
  logic [NUM_CH-1:0][DW-1:0] duty_w;
  logic [NUM_CH-1:0]         blank_w;

  pmd_frame_timer #(.DW(DW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && (wr_ch_i == CW'(c));
    pmd_channel #(.DW(DW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wrap_i     (wrap_w),
      .cnt_i      (cnt_w),
      .wr_i       (sel),
      .wr_data_i  (wr_data_i),
      .moire_en_i (moire_en_i[c]),
      .pwm_o      (pwm_o[c]),
      .duty_o     (duty_w[c]),
      .blank_o    (blank_w[c])
    );
  end
endmodule

// File: rtl/pwm_moire_dac_chk.sv
module pwm_moire_dac_chk #(
  parameter int NUM_CH = 2,
  parameter int DW     = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_CH-1:0]         moire_en_i,
  input logic [NUM_CH-1:0]         pwm_o,
  input logic [DW-1:0]             cnt_i,
  input logic                      wrap_i,
  input logic [NUM_CH-1:0][DW-1:0] duty_i,
  input logic [NUM_CH-1:0]         blank_i
);
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (cnt_i == '0));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> (cnt_i == DW'($past(cnt_i) + 1'b1)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap_i |=> $stable(duty_i[c]));
    p_blank_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blank_i[c] |-> !pwm_o[c]);
    p_alt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_i && blank_i[c]) |=> !blank_i[c]);
    p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_i && !moire_en_i[c]) |=> !blank_i[c]);
    p_stay_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap_i |=> $stable(blank_i[c]));
  end
endmodule

bind pwm_moire_dac pwm_moire_dac_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .moire_en_i (moire_en_i),
  .pwm_o      (pwm_o),
  .cnt_i      (cnt_w),
  .wrap_i     (wrap_w),
  .duty_i     (duty_w),
  .blank_i    (blank_w)
);

// File: tb/pwm_moire_dac_test.sv
`timescale 1ns/1ps
module pwm_moire_dac_test;
  localparam int FR = 255;
  localparam int NF = 300;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [0:0] wr_ch_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] moire_en_i = '0;
  logic [1:0] pwm_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk_i = ~clk_i;

  pwm_moire_dac uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_ch_i    (wr_ch_i),
    .wr_data_i  (wr_data_i),
    .moire_en_i (moire_en_i),
    .pwm_o      (pwm_o)
  );

  function automatic int val(int c, int f);
    if (c == 0) return (f * 97 + 5) & 255;
    return 255 - ((f * 53 + 11) & 255);
  endfunction

  function automatic bit en(int c, int f);
    if (c == 0) return ((f / 7) % 2) == 1;
    return ((f / 5) % 3) != 0;
  endfunction

  int  exp_duty [2];
  bit  ph       [2];
  bit  lat      [2];
  bit  dis      [2];
  bit  bad      [2];
  int  first_bad_k [2];
  bit  first_bad_v [2];

  initial begin
    #1;
    n_tests++;
    if (pwm_o !== 2'b00) begin
      n_fail++;
      $display("FAIL R1 outputs in reset: got %b expected 00", pwm_o);
    end
    #20;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int f = 0; f < NF; f++) begin
      for (int c = 0; c < 2; c++) begin
        if (f == 0) begin
          exp_duty[c] = 0; ph[c] = 1'b0; lat[c] = 1'b0; dis[c] = 1'b0;
        end else begin
          bit nl;
          nl = en(c, f - 1);
          ph[c] = (lat[c] && nl) ? ~ph[c] : 1'b0;
          dis[c] = lat[c] && !nl;
          lat[c] = nl;
          exp_duty[c] = val(c, f - 1);
        end
        bad[c] = 1'b0;
      end
      for (int k = 0; k < FR; k++) begin
        for (int c = 0; c < 2; c++) begin
          bit e;
          e = !ph[c] && (k < exp_duty[c]);
          if (pwm_o[c] !== e && !bad[c]) begin
            bad[c] = 1'b1; first_bad_k[c] = k; first_bad_v[c] = pwm_o[c];
          end
        end
        wr_en_i = 1'b0;
        if (k == 100) begin
          wr_en_i = 1'b1; wr_ch_i = 1'b0; wr_data_i = 8'(~val(0, f));
          moire_en_i = {en(1, f), en(0, f)};
        end else if (k == 150) begin
          wr_en_i = 1'b1; wr_ch_i = 1'b1; wr_data_i = 8'(val(1, f));
        end else if (k == 200) begin
          wr_en_i = 1'b1; wr_ch_i = 1'b0; wr_data_i = 8'(val(0, f));
        end
        @(negedge clk_i);
      end
      for (int c = 0; c < 2; c++) begin
        string tag;
        if (f == 0) tag = "R1";
        else if (ph[c]) tag = "R6 R8";
        else if (dis[c]) tag = "R7";
        else if (exp_duty[c] == 0 || exp_duty[c] == 255) tag = "R3";
        else tag = "R2 R4 R5";
        n_tests++;
        if (bad[c]) begin
          n_fail++;
          $display("FAIL %s frame %0d ch%0d step %0d: got %b expected %b (duty %0d blank %0d)",
                   tag, f, c, first_bad_k[c], first_bad_v[c], ~first_bad_v[c],
                   exp_duty[c], ph[c]);
        end
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule